// File: doc/BRIEF.md
# Serial Link Event Receiver

This block sits behind a high-speed serial transceiver. It takes the link as a stream of 16-bit halfwords with a valid strobe and rebuilds each event as a sequence of 32-bit words for a downstream readout FIFO. Two state machines share the work. A link-side writer pushes every arriving halfword into a small receive FIFO. An event-side reader drains that FIFO, checks each packet's CRC16 and emits the packed words, followed by one status trailer word per event.

On the link, an event is a run of payload halfwords, then one CRC field halfword, then the delimiter 0xFE00. The reader keeps one halfword in hand, so when the delimiter arrives the held halfword is known to be the CRC field. An empty receive FIFO presents the filler halfword 0xFF00. The reader never takes that filler as data. It also discards a spurious filler-like halfword at the head of an event, because such a halfword would shift the event by two bytes and hide its delimiter.

Top module: `slr_event_receiver`

## Requirements
- R1: Output data words pack halfwords in arrival order, big-endian: the earlier halfword goes to bits [31:16] and the later one to bits [15:0]. The payload halfwords and then the CRC field halfword are packed this way.
- R2: Each event ends with exactly one trailer word, marked by `out_last` = 1, with layout [31] CRC mismatch, [30] data lost to overflow, [29:16] zero, [15:0] error count. `out_last` is never high without `out_valid`.
- R3: The CRC is CRC16 with polynomial 0x1021 and initial value 0xFFFF. It is fed MSB first, one whole halfword per step, over every payload halfword of the event and excluding the CRC field. Trailer bit [31] is set when the result differs from the received CRC field.
- R4: Trailer bits [15:0] carry a running count of events that failed the CRC, counted since reset and including the current event. The count saturates at 0xFFFF.
- R5: While the reader waits for a new event (state R_IDLE), it discards any halfword whose upper byte is 0xFF and any stray 0xFE00. None of these appears in the output.
- R6: The halfword 0xFE00 closes the event. If the packed halfword count (payload plus CRC field) is odd, the last data word carries the final halfword in [31:16] and 0x0000 in [15:0].
- R7: The reader never pops an empty receive FIFO. Gaps in the link stream mid-event produce no filler words in the output.
- R8: When `out_full` is high at a clock edge, no word is presented in the following cycle. Backpressure loses no word and reorders none.
- R9: A halfword that arrives while the receive FIFO is full is dropped. It sets `ovf_sticky`, which stays high until reset, and it sets trailer bit [30] of the event that receives the next accepted halfword.
- R10: During reset, `out_valid`, `out_last` and `ovf_sticky` are all low.
- R11: A halfword with upper byte 0xFF inside the body of an event is kept as ordinary payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_valid | input | 1 | Link halfword strobe |
| lnk_data | input | 16 | Link halfword |
| out_full | input | 1 | Downstream FIFO full; stalls the reader |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 32 | Packed data or trailer word |
| out_last | output | 1 | Marks the trailer word of an event |
| ovf_sticky | output | 1 | Receive FIFO overflow seen since reset |

Writer states: W_PASS (normal), W_DROP (a halfword was dropped). A drop moves the writer W_PASS→W_DROP. The next accepted halfword is tagged damaged and moves it W_DROP→W_PASS. Reader states: R_IDLE→R_BODY on a valid event start. R_BODY→R_TRAIL on the delimiter when a half word is pending, otherwise R_BODY→R_PAD. R_PAD→R_TRAIL and R_TRAIL→R_IDLE each take one unstalled cycle.

## Verification
The hardest case to reach from the ports is a receive FIFO overflow that lands in the middle of an event while that event's delimiter still gets through. The bench holds `out_full` high so the reader cannot pop. It streams more payload halfwords than the FIFO holds and checks `ovf_sticky`. It then releases the stall, lets the reader drain, and only afterwards sends the CRC field and the delimiter. The trailer must then show both the lost-data bit and the CRC mismatch, and the overflow is not allowed to merge two events.

// File: rtl/slr_pkg.sv
`timescale 1ns/1ps
package slr_pkg;

    localparam int          HW_W        = 16;
    localparam int          WORD_W      = 32;
    localparam int          ERR_W       = 16;
    localparam logic [15:0] FILL_HW     = 16'hFF00;
    localparam logic [15:0] DELIM_HW    = 16'hFE00;
    localparam logic [7:0]  BAD_LEAD    = 8'hFF;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_INIT    = 16'hFFFF;

    typedef enum logic {
        W_PASS,
        W_DROP
    } wr_state_t;

    typedef enum logic [1:0] {
        R_IDLE,
        R_BODY,
        R_PAD,
        R_TRAIL
    } rd_state_t;

    // one CRC16 step over a whole halfword, most significant bit first
    function automatic logic [15:0] crc16_hw(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 15; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/slr_rx_fifo.sv
`timescale 1ns/1ps
module slr_rx_fifo #(
    parameter int          WIDTH = 17,
    parameter int          DEPTH = 16,
    parameter logic [15:0] FILL  = 16'hFF00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    // an empty FIFO presents the filler halfword
    assign rdata   = empty ? WIDTH'(FILL) : mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/slr_link_writer.sv
`timescale 1ns/1ps
module slr_link_writer
    import slr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lnk_valid,
    input  logic [HW_W-1:0] lnk_data,
    input  logic            fifo_full,
    output logic            fifo_push,
    output logic [HW_W:0]   fifo_wdata,
    output logic            ovf_sticky
);
    wr_state_t state_q, state_d;
    logic      drop;

    assign drop = lnk_valid && fifo_full;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_PASS: if (drop) state_d = W_DROP;
            W_DROP: if (lnk_valid && !fifo_full) state_d = W_PASS;
            default: state_d = W_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_PASS;
        else        state_q <= state_d;
    end

    always_comb begin
        fifo_push  = lnk_valid && !fifo_full;
        // bit HW_W tags the first halfword accepted after a drop
        fifo_wdata = {state_q == W_DROP, lnk_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_sticky <= 1'b0;
        else if (drop) ovf_sticky <= 1'b1;
    end
endmodule

// File: rtl/slr_event_reader.sv
`timescale 1ns/1ps
module slr_event_reader
    import slr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HW_W:0]     fifo_rdata,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    input  logic              out_full,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    rd_state_t       state_q, state_d;
    logic [HW_W-1:0] rd_hw, hold_q, hi_q, crc_q;
    logic            rd_dmg, have_hi, crc_bad_q, lost_q;
    logic            is_delim, bad_start, crc_miss;
    logic [ERR_W-1:0] err_cnt;

    assign rd_hw     = fifo_rdata[HW_W-1:0];
    assign rd_dmg    = fifo_rdata[HW_W];
    assign is_delim  = (rd_hw == DELIM_HW);
    assign bad_start = (rd_hw[15:8] == BAD_LEAD) || is_delim;
    assign crc_miss  = (crc_q != hold_q);

    always_comb begin
        fifo_pop = !out_full && !fifo_empty &&
                   ((state_q == R_IDLE) || (state_q == R_BODY));
        state_d  = state_q;
        unique case (state_q)
            R_IDLE:  if (fifo_pop && !bad_start) state_d = R_BODY;
            R_BODY:  if (fifo_pop && is_delim)   state_d = have_hi ? R_TRAIL : R_PAD;
            R_PAD:   if (!out_full)              state_d = R_TRAIL;
            R_TRAIL: if (!out_full)              state_d = R_IDLE;
            default: state_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hi_q      <= '0;
            have_hi   <= 1'b0;
            crc_q     <= CRC_INIT;
            crc_bad_q <= 1'b0;
            lost_q    <= 1'b0;
            err_cnt   <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            unique case (state_q)
                R_IDLE: begin
                    if (fifo_pop && !bad_start) begin
                        hold_q    <= rd_hw;
                        crc_q     <= CRC_INIT;
                        have_hi   <= 1'b0;
                        crc_bad_q <= 1'b0;
                        lost_q    <= rd_dmg;
                    end
                end
                R_BODY: begin
                    if (fifo_pop) begin
                        lost_q <= lost_q | rd_dmg;
                        // the held halfword is packed either way
                        if (have_hi) begin
                            out_valid <= 1'b1;
                            out_data  <= {hi_q, hold_q};
                            have_hi   <= 1'b0;
                        end else begin
                            hi_q    <= hold_q;
                            have_hi <= 1'b1;
                        end
                        if (is_delim) begin
                            // held halfword is the CRC field
                            crc_bad_q <= crc_miss;
                            if (crc_miss && (err_cnt != '1)) err_cnt <= err_cnt + 1'b1;
                        end else begin
                            crc_q  <= crc16_hw(crc_q, hold_q);
                            hold_q <= rd_hw;
                        end
                    end
                end
                R_PAD: begin
                    if (!out_full) begin
                        out_valid <= 1'b1;
                        out_data  <= {hi_q, 16'h0000};
                        have_hi   <= 1'b0;
                    end
                end
                R_TRAIL: begin
                    if (!out_full) begin
                        out_valid <= 1'b1;
                        out_last  <= 1'b1;
                        out_data  <= {crc_bad_q, lost_q, 14'b0, err_cnt};
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/slr_event_receiver.sv
`timescale 1ns/1ps
module slr_event_receiver
    import slr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lnk_valid,
    input  logic [15:0] lnk_data,
    input  logic        out_full,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        out_last,
    output logic        ovf_sticky
);
    logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [HW_W:0] fifo_wdata, fifo_rdata;

    slr_link_writer u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .lnk_valid  (lnk_valid),
        .lnk_data   (lnk_data),
        .fifo_full  (fifo_full),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata),
        .ovf_sticky (ovf_sticky)
    );

    slr_rx_fifo #(
        .WIDTH (HW_W + 1),
        .DEPTH (FIFO_DEPTH),
        .FILL  (FILL_HW)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    slr_event_reader u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_rdata (fifo_rdata),
        .fifo_empty (fifo_empty),
        .fifo_pop   (fifo_pop),
        .out_full   (out_full),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last)
    );
endmodule

// File: rtl/slr_checker.sv
`timescale 1ns/1ps
module slr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lnk_valid,
    input logic        out_full,
    input logic        out_valid,
    input logic        out_last,
    input logic [31:0] out_data,
    input logic        ovf_sticky,
    input logic        fifo_push,
    input logic        fifo_pop,
    input logic        fifo_full,
    input logic        fifo_empty
);
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$past(out_full));

    p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_trailer_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (out_data[29:16] == 14'b0));

    p_no_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_pop && fifo_empty));

    p_no_full_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && fifo_full));

    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && fifo_full) |=> ovf_sticky);

    p_ovf_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);
endmodule

bind slr_event_receiver slr_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lnk_valid  (lnk_valid),
    .out_full   (out_full),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .out_data   (out_data),
    .ovf_sticky (ovf_sticky),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty)
);

// File: tb/test_slr_event_receiver.sv
`timescale 1ns/1ps
module test_slr_event_receiver;
    localparam int DEPTH = 16;
    localparam int NROWS = 8;
    // row: {npay[7:0], seed[7:0], 4'b0, gap, embed_ff, lead_junk, corrupt}
    localparam logic [23:0] ROWS [NROWS] = '{
        {8'd4, 8'd1, 4'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd5, 8'd2, 4'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd3, 8'd3, 4'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd6, 8'd4, 4'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd7, 8'd5, 4'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd5, 8'd6, 4'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd1, 8'd7, 4'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'd9, 8'd8, 4'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lnk_valid = 1'b0;
    logic [15:0] lnk_data = '0;
    logic        out_full = 1'b0;
    logic        out_valid, out_last, ovf_sticky;
    logic [31:0] out_data;

    int tests = 0;
    int fails = 0;
    int bp_viol = 0;
    logic [15:0] exp_err = '0;
    logic        full_at_edge = 1'b0;
    logic [32:0] got_q [$];
    logic [32:0] exp_q [$];
    logic [15:0] pay [0:31];

    slr_event_receiver #(.FIFO_DEPTH(DEPTH)) i_slr_event_receiver (
        .clk(clk), .rst_n(rst_n), .lnk_valid(lnk_valid), .lnk_data(lnk_data),
        .out_full(out_full), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .ovf_sticky(ovf_sticky)
    );

    always #10 clk = ~clk;

    always @(posedge clk) full_at_edge <= out_full;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_q.push_back({out_last, out_data});
            if (full_at_edge) bp_viol++;
        end
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--)
            r = (r[15] ^ d[b]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_hw(input logic [15:0] h, input bit gap);
        @(negedge clk);
        lnk_valid = 1'b1;
        lnk_data  = h;
        @(negedge clk);
        lnk_valid = 1'b0;
        if (gap) repeat (3) @(negedge clk);
    endtask

    function automatic logic [15:0] gen_hw(input int seed, input int i, input bit embed);
        logic [15:0] h = 16'(seed * 16'h03B1 + i * 16'h1F35 + 16'h2468);
        if (h == 16'hFE00) h = 16'hFE01;
        if (embed && i == 2) h = 16'hFF00;
        if (i == 0 && h[15:8] == 8'hFF) h[15:8] = 8'h21;
        return h;
    endfunction

    // expected output for payload pay[0..n-1] plus a CRC field (R1 R2 R3 R4 R6)
    task automatic build_exp(input int n, input logic [15:0] field, input bit lost);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] lst [0:32];
        bit bad;
        for (int i = 0; i < n; i++) begin
            c = ref_crc(c, pay[i]);
            lst[i] = pay[i];
        end
        lst[n] = field;
        bad = (c != field);
        if (bad) exp_err++;
        for (int i = 0; i <= n; i += 2)
            exp_q.push_back({1'b0, lst[i], (i + 1 <= n) ? lst[i+1] : 16'h0000});
        exp_q.push_back({1'b1, bad, lost, 14'b0, exp_err});
    endtask

    task automatic compare(input string req);
        int k = 0;
        while (got_q.size() < exp_q.size() && k < 400) begin
            @(negedge clk);
            k++;
        end
        repeat (6) @(negedge clk);
        chk(got_q.size() == exp_q.size(), {req, " word count"}, 33'(got_q.size()), 33'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic run_event(input int n, input int seed, input bit corrupt,
                             input bit lead, input bit embed, input bit gap, input string req);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] field;
        for (int i = 0; i < n; i++) begin
            pay[i] = gen_hw(seed, i, embed);
            c = ref_crc(c, pay[i]);
        end
        field = corrupt ? (c ^ 16'h0101) : c;
        if (field == 16'hFE00) field = 16'h7E00;
        if (lead) begin
            send_hw(16'hFF00, 1'b0);   // R5 filler at event start
            send_hw(16'hFE00, 1'b0);   // R5 stray delimiter while idle
            send_hw(16'hFF34, 1'b0);   // R5 any 0xFF upper byte at start
        end
        for (int i = 0; i < n; i++) send_hw(pay[i], gap);
        send_hw(field, gap);
        send_hw(16'hFE00, gap);
        build_exp(n, field, 1'b0);
        compare(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid in reset", 33'(out_valid), 33'd0);
        chk(out_last == 1'b0, "R10 out_last in reset", 33'(out_last), 33'd0);
        chk(ovf_sticky == 1'b0, "R10 ovf_sticky in reset", 33'(ovf_sticky), 33'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table of events: R1 R2 R3 R4 R5 R6 R7 R11
        for (int r = 0; r < NROWS; r++)
            run_event(int'(ROWS[r][23:16]), int'(ROWS[r][15:8]), ROWS[r][0], ROWS[r][1],
                      ROWS[r][2], ROWS[r][3], "R1/R3/R5/R6/R7/R11 table event");

        // R9 no overflow so far
        chk(ovf_sticky == 1'b0, "R9 no overflow yet", 33'(ovf_sticky), 33'd0);

        // R8 backpressure with a toggling full signal
        bp_viol = 0;
        fork
            run_event(6, 11, 1'b0, 1'b0, 1'b0, 1'b0, "R8 backpressured event");
            begin
                for (int k = 0; k < 60; k++) begin
                    @(negedge clk);
                    out_full = (k % 3 != 2);
                end
                out_full = 1'b0;
            end
        join
        chk(bp_viol == 0, "R8 word during stall", 33'(bp_viol), 33'd0);

        // R9 overflow mid-event
        begin
            logic [15:0] c = 16'hFFFF;
            logic [15:0] full_pay [0:17];
            @(negedge clk);
            out_full = 1'b1;
            for (int i = 0; i < 18; i++) begin
                full_pay[i] = gen_hw(21, i, 1'b0);
                c = ref_crc(c, full_pay[i]);
            end
            for (int i = 0; i < 18; i++) send_hw(full_pay[i], 1'b0);
            chk(ovf_sticky == 1'b1, "R9 sticky set", 33'(ovf_sticky), 33'd1);
            @(negedge clk);
            out_full = 1'b0;
            repeat (40) @(negedge clk);
            if (c == 16'hFE00) c = 16'h7E00;
            send_hw(c, 1'b0);
            send_hw(16'hFE00, 1'b0);
            for (int i = 0; i < DEPTH; i++) pay[i] = full_pay[i];
            build_exp(DEPTH, c, 1'b1);
            compare("R9 overflowed event trailer");
            chk(ovf_sticky == 1'b1, "R9 sticky held", 33'(ovf_sticky), 33'd1);
        end

        // R4 count keeps running after overflow
        run_event(2, 30, 1'b1, 1'b0, 1'b0, 1'b0, "R4 count after overflow");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule